// File: doc/BRIEF.md
# Grouped priority interrupt encoder

This block gathers interrupt requests from three ranked groups and packs them into a single 32-bit encoded status word. The critical group has three unmaskable inputs. The main group has seventeen source slots, each with a mask bit. The peripheral group has thirty-two inputs, each with a mask bit and a two-level boost setting. Each group has its own field in the status word, made of a valid flag and a source code. Software reads the word and services the highest-ranked group whose flag is set. Critical ranks above main, and main ranks above peripheral.

A boosted peripheral source can be reported through a reserved code in the critical field (high boost) or in the main field (medium boost). When that happens, the peripheral field names the actual source. All request inputs pass through one register stage. The status word is built combinationally from that registered request state and from the mask and boost registers. A small synchronous register port sets the masks and boosts and can read back every register, including the status word.

Top module: `grouped_irq_encoder`

## Requirements
- R1: Critical field: valid flag at bit 10, code at bits 9:8. Critical inputs 0, 1 and 2 report codes 0, 1 and 3. Critical inputs cannot be masked. The lowest code that is active wins.
- R2: Main field: valid flag at bit 21, code at bits 20:16. Main source n reports code n, and the lowest active code wins. Input 4 of the main group is ignored, because code 4 is reserved.
- R3: Peripheral field: valid flag at bit 29, code at bits 28:24. When no boost applies, the lowest-numbered pending unmasked peripheral source wins.
- R4: Masks are active high. Main source n is masked by bit 16-n of the word at address 0. Peripheral source n is masked by bit 31-n of the word at address 1. A masked source is reported in no field.
- R5: After reset, the main mask reads 0x00010FFF, the peripheral mask reads 0x7FFFFC00, and both boost words read 0.
- R6: Peripheral source n has a boost setting. For n = 0..15 it sits at bits 2n+1:2n of address 2. For n = 16..31 it sits at bits 2(n-16)+1:2(n-16) of address 3. A value of 2 (high) makes the critical field report code 2 when the source is pending and unmasked, so it ranks below critical inputs 0 and 1 and above input 2. A value of 3 acts like 0.
- R7: A boost value of 1 (medium) makes the main field report code 4 when the source is pending and unmasked. It then ranks below main sources 0..3 and above sources 5..16.
- R8: The peripheral field picks the lowest-numbered source among the high-boosted candidates if there are any. If there are none, it picks among the medium-boosted candidates, and otherwise among all candidates.
- R9: A field whose valid flag is clear carries code 0. All status bits outside the three fields are 0.
- R10: The status word reflects requests sampled at the previous clock edge. A register write takes effect on the status word right after its write edge.
- R11: A read returns data on the cycle after it is requested and changes no state. Address 4 returns the status word. Writes to address 4 and to addresses 5..7 are ignored, and reads from addresses 5..7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| critReq | input | 3 | Critical group requests |
| mainReq | input | 17 | Main group requests (bit 4 unused) |
| perReq | input | 32 | Peripheral group requests |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |
| statusWord | output | 32 | Encoded status word |

## Verification
The bench builds the block with its default sizes: three critical inputs, seventeen main slots and thirty-two peripheral inputs. At that size every single source and every pair of main sources and of peripheral sources can be swept exhaustively. Each source is also boosted in turn, at each of the four setting values, against the critical and main inputs that bracket the reserved codes. A long run of pseudo-random mixes of requests, masks and boosts then compares the whole status word with an arithmetic model.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

  localparam int ADDR_MAIN_MASK = 0;
  localparam int ADDR_PER_MASK  = 1;
  localparam int ADDR_BOOST_LO  = 2;
  localparam int ADDR_BOOST_HI  = 3;
  localparam int ADDR_STATUS    = 4;

  localparam int BOOST_W   = 2;
  localparam int BOOST_MED = 1;
  localparam int BOOST_HIGH = 2;

  typedef enum logic [2:0] {
    RD_MAIN_MASK,
    RD_PER_MASK,
    RD_BOOST_LO,
    RD_BOOST_HI,
    RD_STATUS,
    RD_NONE
  } rdSel_e;

  typedef struct packed {
    logic       wrMainMask;
    logic       wrPerMask;
    logic [1:0] wrBoost;
    logic       rdEn;
    rdSel_e     rdSel;
  } regStrobes_t;

endpackage

// File: rtl/irq_lowest_first.sv
module irq_lowest_first #(
  parameter int W = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_enc_ctrl.sv
module irq_enc_ctrl
  import irq_enc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobes_t       strb
);

  always_comb begin
    strb            = '0;
    strb.rdEn       = regRdEn;
    strb.rdSel      = RD_NONE;
    strb.wrMainMask = regWrEn && (regAddr == ADDR_W'(ADDR_MAIN_MASK));
    strb.wrPerMask  = regWrEn && (regAddr == ADDR_W'(ADDR_PER_MASK));
    strb.wrBoost[0] = regWrEn && (regAddr == ADDR_W'(ADDR_BOOST_LO));
    strb.wrBoost[1] = regWrEn && (regAddr == ADDR_W'(ADDR_BOOST_HI));
    if      (regAddr == ADDR_W'(ADDR_MAIN_MASK)) strb.rdSel = RD_MAIN_MASK;
    else if (regAddr == ADDR_W'(ADDR_PER_MASK))  strb.rdSel = RD_PER_MASK;
    else if (regAddr == ADDR_W'(ADDR_BOOST_LO))  strb.rdSel = RD_BOOST_LO;
    else if (regAddr == ADDR_W'(ADDR_BOOST_HI))  strb.rdSel = RD_BOOST_HI;
    else if (regAddr == ADDR_W'(ADDR_STATUS))    strb.rdSel = RD_STATUS;
  end

endmodule

// File: rtl/irq_enc_datapath.sv
module irq_enc_datapath
  import irq_enc_pkg::*;
#(
  parameter int          NUM_CRIT      = 3,
  parameter int          NUM_MAIN      = 17,
  parameter int          NUM_PER       = 32,
  parameter int          DATA_W        = 32,
  parameter int          MAIN_RSVD     = 4,
  parameter logic [31:0] MAIN_MASK_RST = 32'h0001_0FFF,
  parameter logic [31:0] PER_MASK_RST  = 32'h7FFF_FC00
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobes_t         strb,
  input  logic [NUM_CRIT-1:0] critReq,
  input  logic [NUM_MAIN-1:0] mainReq,
  input  logic [NUM_PER-1:0]  perReq,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   statusWord
);

  localparam int PER_PER_WORD = DATA_W / BOOST_W;
  localparam int MAIN_IDX_W   = $clog2(NUM_MAIN);
  localparam int PER_IDX_W    = $clog2(NUM_PER);
  localparam int CRIT_SLOTS   = NUM_CRIT + 1;
  localparam int CRIT_IDX_W   = $clog2(CRIT_SLOTS);

  logic [NUM_CRIT-1:0] critPend;
  logic [NUM_MAIN-1:0] mainPend;
  logic [NUM_PER-1:0]  perPend;
  logic [NUM_MAIN-1:0] mainMask;
  logic [NUM_PER-1:0]  perMask;
  logic [NUM_MAIN-1:0] mainMaskNat;
  logic [NUM_PER-1:0]  perMaskNat;
  logic [BOOST_W-1:0]  boostLvl [NUM_PER];
  logic [2*DATA_W-1:0] boostFlat;

  logic [NUM_PER-1:0]  perEff, hiSet, medSet, perCand;
  logic [NUM_MAIN-1:0] mainCand;
  logic [CRIT_SLOTS-1:0] critCand;

  logic                  critValid, mainValid, perValid;
  logic [CRIT_IDX_W-1:0] critCode;
  logic [MAIN_IDX_W-1:0] mainCode;
  logic [PER_IDX_W-1:0]  perCode;

  // request sampling and mask registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      critPend <= '0;
      mainPend <= '0;
      perPend  <= '0;
      mainMask <= MAIN_MASK_RST[NUM_MAIN-1:0];
      perMask  <= PER_MASK_RST[NUM_PER-1:0];
    end else begin
      critPend <= critReq;
      mainPend <= mainReq;
      perPend  <= perReq;
      if (strb.wrMainMask) mainMask <= wrData[NUM_MAIN-1:0];
      if (strb.wrPerMask)  perMask  <= wrData[NUM_PER-1:0];
    end
  end

  // per-source boost storage and source-order views of the masks
  for (genvar n = 0; n < NUM_PER; n++) begin : g_per
    localparam int WORD = n / PER_PER_WORD;
    localparam int SLOT = n % PER_PER_WORD;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  boostLvl[n] <= '0;
      else if (strb.wrBoost[WORD]) boostLvl[n] <= wrData[SLOT*BOOST_W +: BOOST_W];
    end
    assign boostFlat[n*BOOST_W +: BOOST_W] = boostLvl[n];
    assign perMaskNat[n] = perMask[NUM_PER-1-n];
    assign perEff[n]     = perPend[n] && !perMaskNat[n];
    assign hiSet[n]      = perEff[n] && (boostLvl[n] == BOOST_W'(BOOST_HIGH));
    assign medSet[n]     = perEff[n] && (boostLvl[n] == BOOST_W'(BOOST_MED));
  end
  if (2 * DATA_W > NUM_PER * BOOST_W) begin : g_pad
    assign boostFlat[2*DATA_W-1:NUM_PER*BOOST_W] = '0;
  end

  for (genvar n = 0; n < NUM_MAIN; n++) begin : g_main
    assign mainMaskNat[n] = mainMask[NUM_MAIN-1-n];
    if (n == MAIN_RSVD) begin : g_rsvd
      assign mainCand[n] = |medSet;
    end else begin : g_src
      assign mainCand[n] = mainPend[n] && !mainMaskNat[n];
    end
  end

  // critical slots in code order: in0, in1, boosted-high, in2
  assign critCand = {critPend[2], |hiSet, critPend[1], critPend[0]};
  assign perCand  = (|hiSet) ? hiSet : ((|medSet) ? medSet : perEff);

  irq_lowest_first #(.W(CRIT_SLOTS)) i_critEnc (.req(critCand), .found(critValid), .idx(critCode));
  irq_lowest_first #(.W(NUM_MAIN))   i_mainEnc (.req(mainCand), .found(mainValid), .idx(mainCode));
  irq_lowest_first #(.W(NUM_PER))    i_perEnc  (.req(perCand),  .found(perValid),  .idx(perCode));

  always_comb begin
    statusWord        = '0;
    statusWord[10]    = critValid;
    statusWord[9:8]   = critCode;
    statusWord[21]    = mainValid;
    statusWord[20:16] = mainCode;
    statusWord[29]    = perValid;
    statusWord[28:24] = perCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_MAIN_MASK: rdData <= DATA_W'(mainMask);
        RD_PER_MASK:  rdData <= DATA_W'(perMask);
        RD_BOOST_LO:  rdData <= boostFlat[DATA_W-1:0];
        RD_BOOST_HI:  rdData <= boostFlat[2*DATA_W-1:DATA_W];
        RD_STATUS:    rdData <= statusWord;
        default:      rdData <= '0;
      endcase
    end
  end

  assert_crit_in0_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(critReq[0])) |-> (statusWord[10] && statusWord[9:8] == 2'd0));

  assert_main_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mainPend[MAIN_RSVD] && !statusWord[29]) |-> !(statusWord[21] && statusWord[20:16] == 5'd4));

  assert_per_unmasked_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[29] |-> (perPend[perCode] && !perMaskNat[perCode]));

  assert_crit_boost_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[10] && statusWord[9:8] == 2'd2) |->
      (statusWord[29] && boostLvl[statusWord[28:24]] == BOOST_W'(BOOST_HIGH)));

  assert_main_boost_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[21] && statusWord[20:16] == 5'd4) |-> statusWord[29]);

  assert_idle_code_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[29] |-> statusWord[28:24] == 5'd0) and
    (!statusWord[21] |-> statusWord[20:16] == 5'd0));

  assert_read_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrMainMask && !strb.wrPerMask && strb.wrBoost == 2'b00) |=>
      ($stable(mainMask) && $stable(perMask) && $stable(boostFlat)));

endmodule

// File: rtl/grouped_irq_encoder.sv
module grouped_irq_encoder
  import irq_enc_pkg::*;
#(
  parameter int NUM_CRIT = 3,
  parameter int NUM_MAIN = 17,
  parameter int NUM_PER  = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CRIT-1:0] critReq,
  input  logic [NUM_MAIN-1:0] mainReq,
  input  logic [NUM_PER-1:0]  perReq,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [DATA_W-1:0]   statusWord
);

  regStrobes_t strb;

  irq_enc_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irq_enc_datapath #(
    .NUM_CRIT (NUM_CRIT),
    .NUM_MAIN (NUM_MAIN),
    .NUM_PER  (NUM_PER),
    .DATA_W   (DATA_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .critReq    (critReq),
    .mainReq    (mainReq),
    .perReq     (perReq),
    .wrData     (regWrData),
    .rdData     (regRdData),
    .statusWord (statusWord)
  );

endmodule

// File: tb/test_grouped_irq_encoder.sv
module test_grouped_irq_encoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  critReq = '0;
  logic [16:0] mainReq = '0;
  logic [31:0] perReq = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] statusWord;

  int testCnt = 0;
  int failCnt = 0;

  logic [16:0] mm;
  logic [31:0] pm;
  logic [63:0] bst;

  grouped_irq_encoder i_grouped_irq_encoder (
    .clk(clk), .rstN(rstN), .critReq(critReq), .mainReq(mainReq), .perReq(perReq),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .statusWord(statusWord)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic checkEq(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic applyReq(input logic [2:0] c, input logic [16:0] m, input logic [31:0] p);
    critReq = c; mainReq = m; perReq = p;
    @(negedge clk);
  endtask

  task automatic setMasks(input logic [16:0] m, input logic [31:0] p);
    mm = m; pm = p;
    writeReg(3'd0, {15'd0, m});
    writeReg(3'd1, p);
  endtask

  task automatic setBoosts(input logic [63:0] b);
    bst = b;
    writeReg(3'd2, b[31:0]);
    writeReg(3'd3, b[63:32]);
  endtask

  // expected status from the requirement text
  function automatic logic [31:0] model(input logic [2:0] c, input logic [16:0] m, input logic [31:0] p);
    logic [31:0] pe, hi, md, sel, s;
    logic [4:0]  mc;
    logic        mv;
    s = '0;
    for (int n = 0; n < 32; n++) begin
      pe[n] = p[n] && !pm[31-n];
      hi[n] = pe[n] && bst[2*n +: 2] == 2'd2;
      md[n] = pe[n] && bst[2*n +: 2] == 2'd1;
    end
    if (c[0])      begin s[10] = 1'b1; s[9:8] = 2'd0; end
    else if (c[1]) begin s[10] = 1'b1; s[9:8] = 2'd1; end
    else if (|hi)  begin s[10] = 1'b1; s[9:8] = 2'd2; end
    else if (c[2]) begin s[10] = 1'b1; s[9:8] = 2'd3; end
    mv = 1'b0; mc = '0;
    for (int n = 16; n >= 0; n--) begin
      if ((n == 4) ? (|md) : (m[n] && !mm[16-n])) begin mv = 1'b1; mc = 5'(n); end
    end
    s[21] = mv; s[20:16] = mc;
    sel = (|hi) ? hi : ((|md) ? md : pe);
    for (int n = 31; n >= 0; n--) begin
      if (sel[n]) begin s[29] = 1'b1; s[28:24] = 5'(n); end
    end
    return s;
  endfunction

  task automatic checkStatus(input string tag);
    checkEq(tag, statusWord, model(critReq, mainReq, perReq));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    mm = 17'h10FFF; pm = 32'h7FFFFC00; bst = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R5 reset values, R9 idle status
    readReg(3'd0, rd); checkEq("R5 main mask reset", rd, 32'h0001_0FFF);
    readReg(3'd1, rd); checkEq("R5 per mask reset", rd, 32'h7FFF_FC00);
    readReg(3'd2, rd); checkEq("R5 boost lo reset", rd, 32'h0);
    readReg(3'd3, rd); checkEq("R5 boost hi reset", rd, 32'h0);
    checkEq("R9 idle status", statusWord, 32'h0);

    setMasks('0, '0);

    // R1 critical sweep
    for (int c = 0; c < 8; c++) begin
      applyReq(3'(c), '0, '0);
      checkStatus("R1 critical combo");
    end
    applyReq(3'b100, '0, '0);
    checkEq("R1 crit input2 code3", statusWord, 32'h0000_0700);

    // R2 main singles and pairs
    for (int a = 0; a < 17; a++) begin
      applyReq('0, 17'(1) << a, '0);
      checkStatus("R2 main single");
    end
    applyReq('0, 17'(1) << 4, '0);
    checkEq("R2 main input4 ignored", statusWord, 32'h0);
    for (int a = 0; a < 17; a++)
      for (int b = 0; b < 17; b++) begin
        applyReq('0, (17'(1) << a) | (17'(1) << b), '0);
        checkStatus("R2 main pair");
      end

    // R3 peripheral singles and pairs
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++) begin
        applyReq('0, '0, (32'(1) << a) | (32'(1) << b));
        checkStatus("R3 per pair");
      end

    // R4 masks
    for (int n = 0; n < 17; n++) begin
      setMasks(17'(1) << (16 - n), '0);
      applyReq('0, 17'(1) << n, '0);
      checkEq("R4 main masked", statusWord, 32'h0);
    end
    for (int n = 0; n < 32; n++) begin
      setMasks('0, 32'(1) << (31 - n));
      applyReq('0, '0, 32'(1) << n);
      checkEq("R4 per masked", statusWord, 32'h0);
      applyReq('0, '0, 32'hFFFF_FFFF);
      checkStatus("R4 per masked among many");
    end
    setMasks(17'h10000, '0);
    applyReq('0, 17'h00003, '0);
    checkEq("R4 main next after masked", statusWord, 32'h0021_0000);
    setMasks('0, '0);

    // R6 / R7 boost per source with bracketing inputs
    for (int n = 0; n < 32; n++) begin
      for (int v = 0; v < 4; v++) begin
        setBoosts(64'(v) << (2 * n));
        applyReq(3'b100, '0, 32'(1) << n);
        checkStatus("R6 boost vs crit input2");
        applyReq(3'b010, 17'h00008, 32'(1) << n);
        checkStatus("R6 boost vs crit input1");
        applyReq('0, 17'h00020, 32'hFFFF_FFFF);
        checkStatus("R7 boost vs main5");
      end
    end
    setBoosts(64'(1) << 20);
    applyReq('0, 17'h00008, 32'(1) << 10);
    checkEq("R7 main3 beats medium", statusWord, 32'h2A23_0000);
    applyReq('0, 17'h00020, 32'(1) << 10);
    checkEq("R7 medium beats main5", statusWord, 32'h2A24_0000);
    setBoosts(64'(3) << 20);
    applyReq('0, '0, 32'(1) << 10);
    checkEq("R6 boost3 acts as none", statusWord, 32'h2A00_0000);

    // R8 mixed random patterns, R11 status readback
    for (int k = 0; k < 400; k++) begin
      setMasks(17'($urandom & $urandom), $urandom & $urandom);
      setBoosts({$urandom, $urandom});
      applyReq(3'($urandom), 17'($urandom), $urandom);
      checkStatus("R8 mixed pattern");
      if (k % 8 == 0) begin
        readReg(3'd4, rd);
        checkEq("R11 status readback", rd, model(critReq, mainReq, perReq));
      end
    end

    // R11 ignored writes and unmapped reads
    setMasks(17'h0A5A5, 32'h1234_5678);
    setBoosts(64'h0F0F_0F0F_3C3C_3C3C);
    for (int a = 4; a < 8; a++) writeReg(3'(a), 32'hFFFF_FFFF);
    readReg(3'd0, rd); checkEq("R11 main mask kept", rd, 32'h0000_A5A5);
    readReg(3'd1, rd); checkEq("R11 per mask kept", rd, 32'h1234_5678);
    readReg(3'd2, rd); checkEq("R11 boost lo kept", rd, 32'h3C3C_3C3C);
    readReg(3'd3, rd); checkEq("R11 boost hi kept", rd, 32'h0F0F_0F0F);
    for (int a = 5; a < 8; a++) begin
      readReg(3'(a), rd); checkEq("R11 unmapped read zero", rd, 32'h0);
    end

    // R10 timing
    setMasks('0, '0);
    setBoosts('0);
    applyReq('0, '0, '0);
    critReq = 3'b001;
    #1 checkEq("R10 before edge", statusWord, 32'h0);
    @(negedge clk);
    checkEq("R10 after edge", statusWord, 32'h0000_0400);
    critReq = '0; perReq = 32'h0000_0001;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd1; regWrData = 32'h8000_0000;
    #1 checkEq("R10 mask before write edge", statusWord, 32'h2000_0000);
    @(negedge clk);
    regWrEn = 1'b0;
    checkEq("R10 mask after write edge", statusWord, 32'h0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule